// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital edge of one voice-band PCM channel on a time-division bus. On the transmit side it holds an 8-bit companded sample, supplied on a parallel port with a load strobe. It shifts that sample out MSB first in a time slot that the transmit frame sync opens. While its bits are on the line it drives an active-low slot strobe. Outside the slot the serial output is released, which stands for high impedance. On the receive side a second frame sync opens a slot. The 8 bits captured there appear on a parallel port together with a one-cycle valid pulse.

All logic runs on one fast, free-running reference clock. The master (data) clock, both frame syncs and the receive data are sampled in that domain, and turned into rising- and falling-edge events. Transmit bits change on master-clock rising edges and receive bits are taken on falling edges. After reset the outputs stay released for a programmable number of frames. A watchdog on the reference clock releases them when the master clock stops. The same blanking period then runs again once the master clock comes back.

Top module: `pcm_slot_port`

## Requirements
- R1: A frame sync counts as accepted at a master-clock falling edge where it is sampled high, provided it was sampled low at the previous falling edge. After an accepted transmit frame sync, the next SLOT_BITS master-clock rising edges drive the committed word on tx_bit_o, most significant bit (sign) first, one bit per rising edge.
- R2: tx_oe_o goes high and slot_n_o goes low at the first of those rising edges. Both return (tx_oe_o=0, slot_n_o=1) at the falling edge that follows the last bit. At all other times tx_oe_o=0 and slot_n_o=1.
- R3: After an accepted receive frame sync, rx_bit_i is captured at that same falling edge and at the following SLOT_BITS-1 falling edges, first bit as MSB. The word then appears on rx_word_o, and rx_valid_o is high for exactly one clk cycle.
- R4: A tx_load_i pulse stores tx_word_i in a holding register. Each accepted transmit frame sync commits the holding value for that slot, so a word loaded during one frame is sent in the next frame's slot. After reset the holding value is IDLE_WORD (all ones by default).
- R5: A frame sync that rises while a transmit or receive slot is still running is ignored: no extra slot, no extra strobe, no extra valid pulse, and the running word is not disturbed.
- R6: After reset, tx_oe_o stays 0 and slot_n_o stays 1 until BLANK_FRAMES*FRAME_LEN master-clock rising edges have been seen. A slot accepted before that point stays released for its whole length.
- R7: If no master-clock edge is seen for LOSS_CYC clk cycles, tx_oe_o drops to 0 and slot_n_o rises to 1 at once. Any transmit or receive slot in progress is abandoned, and no word is delivered for it.
- R8: After a clock loss, the startup blanking of R6 starts again from zero once master-clock edges return.
- R9: During and right after reset: tx_oe_o=0, slot_n_o=1, tx_bit_o=0, rx_valid_o=0, rx_word_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Master (bit) clock, sampled on clk |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_load_i | input | 1 | One-cycle strobe that stores tx_word_i |
| tx_word_i | input | SLOT_BITS | Next transmit sample |
| tx_bit_o | output | 1 | Serial transmit data (0 when released) |
| tx_oe_o | output | 1 | Serial output driver enable (0 = high impedance) |
| slot_n_o | output | 1 | Active-low transmit slot strobe (1 = released) |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_bit_i | input | 1 | Serial receive data |
| rx_word_o | output | SLOT_BITS | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o is updated |

## Verification
Two functions can meet in the same cycle. One is the frame-sync detector, which may see a new sync while the slot engines are still counting bits. The other is the clock watchdog, which can expire while a bit is on the line. The bench provokes the first by pulsing both frame syncs a second time at the fourth bit clock of a slot, in directed frames and in random frames. It then judges that the strobe releases after exactly eight bits, that nothing more is driven for the rest of the frame, and that only one correctly assembled receive word appears. It provokes the second by stopping the master clock just after the third transmit bit. Before the threshold the bit must still be driven, and after it the outputs must be released with no receive word delivered. The next frames must then be blanked again.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } mclk_evt_t;

  function automatic logic went_high(input logic now_v, input logic old_v);
    return now_v & ~old_v;
  endfunction

  function automatic logic went_low(input logic now_v, input logic old_v);
    return ~now_v & old_v;
  endfunction

  function automatic int blank_len(input int frames, input int frame_len);
    return frames * frame_len;
  endfunction

endpackage

// File: rtl/pcm_mclk_sampler.sv
module pcm_mclk_sampler
  import pcm_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mclk_i,
  input  logic      tx_fs_i,
  input  logic      rx_fs_i,
  input  logic      rx_bit_i,
  output mclk_evt_t evt,
  output logic      tx_sync,
  output logic      rx_sync,
  output logic      rx_bit_s
);
  logic m_now, m_old, tf_now, rf_now, rb_now, tf_old, rf_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_now  <= 1'b0;
      m_old  <= 1'b0;
      tf_now <= 1'b0;
      rf_now <= 1'b0;
      rb_now <= 1'b0;
      tf_old <= 1'b0;
      rf_old <= 1'b0;
    end else begin
      m_now  <= mclk_i;
      m_old  <= m_now;
      tf_now <= tx_fs_i;
      rf_now <= rx_fs_i;
      rb_now <= rx_bit_i;
      if (evt.fall) begin
        tf_old <= tf_now;
        rf_old <= rf_now;
      end
    end
  end

  assign evt.rise = went_high(m_now, m_old);
  assign evt.fall = went_low(m_now, m_old);
  assign tx_sync  = evt.fall & went_high(tf_now, tf_old);
  assign rx_sync  = evt.fall & went_high(rf_now, rf_old);
  assign rx_bit_s = rb_now;
endmodule

// File: rtl/pcm_clk_watch.sv
module pcm_clk_watch #(
  parameter int LOSS_CYC  = 5000,
  parameter int BLANK_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  output logic clk_lost,
  output logic ready
);
  localparam int GW = $clog2(LOSS_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(LOSS_CYC);
  localparam logic [BW-1:0] BLK_MAX = BW'(BLANK_CYC);

  logic [GW-1:0] gap;
  logic [BW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= '0;
    end else begin
      if (rise_ev || fall_ev) gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
      if (clk_lost) seen <= '0;
      else if (rise_ev && seen != BLK_MAX) seen <= seen + 1'b1;
    end
  end

  assign clk_lost = (gap == GAP_MAX);
  assign ready    = (seen == BLK_MAX);
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int SLOT_BITS = 8,
  parameter logic [SLOT_BITS-1:0] IDLE_WORD = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 sync,
  input  logic                 abort,
  input  logic                 ready,
  input  logic                 load,
  input  logic [SLOT_BITS-1:0] word,
  output logic                 drive,
  output logic                 bit_o
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS);

  logic [SLOT_BITS-1:0] hold, shreg;
  logic [CW-1:0]        cnt;
  logic                 armed, on, live, bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= IDLE_WORD;
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
      on    <= 1'b0;
      live  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      if (load) hold <= word;
      if (abort) begin
        armed <= 1'b0;
        on    <= 1'b0;
      end else if (sync && !armed && !on) begin
        armed <= 1'b1;
        shreg <= hold;
        live  <= ready;
      end else if (rise_ev && (armed || (on && cnt != LAST))) begin
        armed <= 1'b0;
        on    <= 1'b1;
        cnt   <= armed ? CW'(1) : cnt + 1'b1;
        bit_q <= shreg[SLOT_BITS-1];
        shreg <= {shreg[SLOT_BITS-2:0], 1'b0};
      end else if (fall_ev && on && cnt == LAST) begin
        on <= 1'b0;
      end
    end
  end

  assign drive = on & live;
  assign bit_o = bit_q;
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_ev,
  input  logic                 sync,
  input  logic                 abort,
  input  logic                 bit_i,
  output logic [SLOT_BITS-1:0] word,
  output logic                 valid
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

  logic [SLOT_BITS-1:0] shreg;
  logic [CW-1:0]        cnt;
  logic                 busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (fall_ev && busy) begin
        shreg <= {shreg[SLOT_BITS-2:0], bit_i};
        if (cnt == LAST) begin
          word  <= {shreg[SLOT_BITS-2:0], bit_i};
          valid <= 1'b1;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (sync) begin
        busy  <= 1'b1;
        shreg <= {shreg[SLOT_BITS-2:0], bit_i};
        cnt   <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int SLOT_BITS    = 8,
  parameter int FRAME_LEN    = 256,
  parameter int BLANK_FRAMES = 4,
  parameter int LOSS_CYC     = 5000,
  parameter logic [SLOT_BITS-1:0] IDLE_WORD = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mclk_i,
  input  logic                 tx_fs_i,
  input  logic                 tx_load_i,
  input  logic [SLOT_BITS-1:0] tx_word_i,
  output logic                 tx_bit_o,
  output logic                 tx_oe_o,
  output logic                 slot_n_o,
  input  logic                 rx_fs_i,
  input  logic                 rx_bit_i,
  output logic [SLOT_BITS-1:0] rx_word_o,
  output logic                 rx_valid_o
);
  localparam int BLANK_CYC = blank_len(BLANK_FRAMES, FRAME_LEN);

  mclk_evt_t evt;
  logic rise_ev, fall_ev, tx_sync, rx_sync, rx_bit_s;
  logic clk_lost, ready, tx_drive, tx_bit_q;

  pcm_mclk_sampler u_smp (
    .clk, .rst_n, .mclk_i, .tx_fs_i, .rx_fs_i, .rx_bit_i,
    .evt, .tx_sync, .rx_sync, .rx_bit_s
  );

  assign rise_ev = evt.rise;
  assign fall_ev = evt.fall;

  pcm_clk_watch #(.LOSS_CYC(LOSS_CYC), .BLANK_CYC(BLANK_CYC)) u_watch (
    .clk, .rst_n, .rise_ev, .fall_ev, .clk_lost, .ready
  );

  pcm_tx_slot #(.SLOT_BITS(SLOT_BITS), .IDLE_WORD(IDLE_WORD)) u_tx (
    .clk, .rst_n, .rise_ev, .fall_ev, .sync(tx_sync), .abort(clk_lost),
    .ready, .load(tx_load_i), .word(tx_word_i), .drive(tx_drive), .bit_o(tx_bit_q)
  );

  pcm_rx_slot #(.SLOT_BITS(SLOT_BITS)) u_rx (
    .clk, .rst_n, .fall_ev, .sync(rx_sync), .abort(clk_lost),
    .bit_i(rx_bit_s), .word(rx_word_o), .valid(rx_valid_o)
  );

  assign tx_oe_o  = tx_drive & ~clk_lost;
  assign slot_n_o = ~tx_oe_o;
  assign tx_bit_o = tx_oe_o & tx_bit_q;
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int SLOT_BITS = 8,
  parameter int LOSS_CYC  = 5000,
  parameter int BLANK_CYC = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic mclk_i,
  input logic rise_ev,
  input logic fall_ev,
  input logic clk_lost,
  input logic tx_oe_o,
  input logic slot_n_o,
  input logic rx_valid_o
);
  localparam int GW = $clog2(LOSS_CYC + 4);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int SW = $clog2(SLOT_BITS + 1);
  localparam logic [GW-1:0] GAP_TOP  = GW'(LOSS_CYC + 3);
  localparam logic [GW-1:0] GAP_LOSS = GW'(LOSS_CYC);
  localparam logic [BW-1:0] BLK_TOP  = BW'(BLANK_CYC);

  logic          mk_q;
  logic [GW-1:0] gap;
  logic [BW-1:0] rises;
  logic [SW-1:0] slot_rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q       <= 1'b0;
      gap        <= '0;
      rises      <= '0;
      slot_rises <= '0;
    end else begin
      mk_q <= mclk_i;
      if (mclk_i != mk_q) gap <= '0;
      else if (gap != GAP_TOP) gap <= gap + 1'b1;
      if (gap >= GAP_LOSS) rises <= '0;
      else if (mclk_i && !mk_q && rises != BLK_TOP) rises <= rises + 1'b1;
      if (!tx_oe_o) slot_rises <= '0;
      else if (rise_ev) slot_rises <= slot_rises + 1'b1;
    end
  end

  // R7: a stopped master clock releases the outputs
  a_r7_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == GAP_TOP) |-> (!tx_oe_o && slot_n_o));

  // R6, R8: no drive before the blanking period has elapsed
  a_r6_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rises != BLK_TOP) |-> !tx_oe_o);

  // R2: driver turns on only after a master-clock rising edge
  a_r2_enable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe_o) |-> $past(rise_ev));

  // R2: driver turns off only after a falling edge or on clock loss
  a_r2_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe_o) |-> ($past(fall_ev) || clk_lost));

  // R5: one slot never spans more than SLOT_BITS rising edges
  a_r5_slot_length: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe_o |-> (slot_rises < SW'(SLOT_BITS)));

  // R3: valid is a single-cycle pulse after a falling edge
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r3_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(fall_ev));
endmodule

bind pcm_slot_port pcm_slot_port_chk #(
  .SLOT_BITS(SLOT_BITS), .LOSS_CYC(LOSS_CYC), .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .rise_ev(rise_ev),
  .fall_ev(fall_ev), .clk_lost(clk_lost), .tx_oe_o(tx_oe_o),
  .slot_n_o(slot_n_o), .rx_valid_o(rx_valid_o)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  localparam int FL = 16;
  localparam int BF = 4;
  localparam int LC = 40;
  localparam int H  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, mclk = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0, rx_bit = 1'b0;
  logic tx_load = 1'b0;
  logic [7:0] tx_word = '0;
  logic tx_bit_o, tx_oe_o, slot_n_o, rx_valid_o;
  logic [7:0] rx_word_o;

  pcm_slot_port #(.SLOT_BITS(8), .FRAME_LEN(FL), .BLANK_FRAMES(BF), .LOSS_CYC(LC)) dut (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .tx_fs_i(tx_fs), .tx_load_i(tx_load),
    .tx_word_i(tx_word), .tx_bit_o(tx_bit_o), .tx_oe_o(tx_oe_o), .slot_n_o(slot_n_o),
    .rx_fs_i(rx_fs), .rx_bit_i(rx_bit), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  int checks = 0, fails = 0, vcnt = 0;
  bit done = 1'b0;
  logic [7:0] vword = '0;
  logic [7:0] hold_m = 8'hFF;

  always @(negedge clk) if (rx_valid_o) begin
    vcnt  = vcnt + 1;
    vword = rx_word_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] w, input int n);
    return w[8 - n];  // bit n of the slot, n=1 is the MSB
  endfunction

  task automatic tick(output logic r_oe, output logic r_bit, output logic r_sn,
                      output logic f_oe, output logic f_sn);
    mclk = 1'b1;
    repeat (H) @(negedge clk);
    r_oe = tx_oe_o; r_bit = tx_bit_o; r_sn = slot_n_o;
    mclk = 1'b0;
    repeat (H) @(negedge clk);
    f_oe = tx_oe_o; f_sn = slot_n_o;
  endtask

  task automatic frame(input logic [7:0] rxw, input bit do_load, input logic [7:0] ldw,
                       input bit live, input bit dbl, input string btag);
    logic [7:0] sent;
    logic ro, rb, rs, fo, fs;
    int v0;
    sent = hold_m;
    v0 = vcnt;
    for (int t = 1; t <= FL; t++) begin
      tx_fs  = (t == 1) || (dbl && t == 4);
      rx_fs  = tx_fs;
      rx_bit = (t <= 8) ? rxw[8 - t] : 1'($urandom);
      tick(ro, rb, rs, fo, fs);
      if (t >= 2 && t <= 9) begin
        if (live) begin
          chk(ro == 1'b1 && rs == 1'b0, "R2 enable/strobe inside slot", {ro, rs}, 2'b10);
          chk(rb == exp_bit(sent, t - 1), "R1 R4 serial bit", rb, exp_bit(sent, t - 1));
        end else begin
          chk(ro == 1'b0 && rs == 1'b1, btag, {ro, rs}, 2'b01);
        end
        if (t == 9) chk(fo == 1'b0 && fs == 1'b1, "R2 release at last falling edge", {fo, fs}, 2'b01);
      end else begin
        chk(ro == 1'b0 && rs == 1'b1 && fo == 1'b0 && fs == 1'b1,
            dbl ? "R5 no extra slot" : "R2 idle outside slot", {ro, rs, fo, fs}, 4'b0101);
      end
      if (do_load && t == 12) begin
        tx_load = 1'b1; tx_word = ldw;
        @(negedge clk);
        tx_load = 1'b0;
        hold_m  = ldw;
        @(negedge clk);
      end
    end
    tx_fs = 1'b0; rx_fs = 1'b0;
    chk(vcnt == v0 + 1, dbl ? "R5 R3 single receive word" : "R3 single receive word", vcnt - v0, 1);
    chk(vword == rxw, "R3 receive word", vword, rxw);
  endtask

  task automatic loss_test(input logic [7:0] rxw);
    logic ro, rb, rs, fo, fs;
    int v0;
    v0 = vcnt;
    for (int t = 1; t <= 4; t++) begin
      tx_fs = (t == 1); rx_fs = tx_fs;
      rx_bit = rxw[8 - t];
      tick(ro, rb, rs, fo, fs);
    end
    tx_fs = 1'b0; rx_fs = 1'b0;
    chk(fo == 1'b1, "R7 slot running before stop", fo, 1);
    repeat (LC - 10) @(negedge clk);
    chk(tx_oe_o == 1'b1 && slot_n_o == 1'b0, "R7 still driven below threshold", {tx_oe_o, slot_n_o}, 2'b10);
    repeat (20) @(negedge clk);
    chk(tx_oe_o == 1'b0 && slot_n_o == 1'b1, "R7 released after clock loss", {tx_oe_o, slot_n_o}, 2'b01);
    chk(tx_bit_o == 1'b0, "R7 data low while released", tx_bit_o, 0);
    chk(vcnt == v0, "R7 aborted receive slot", vcnt - v0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tx_oe_o == 1'b0 && slot_n_o == 1'b1 && tx_bit_o == 1'b0, "R9 outputs released in reset",
        {tx_oe_o, slot_n_o, tx_bit_o}, 3'b010);
    chk(rx_valid_o == 1'b0 && rx_word_o == 8'h00, "R9 receive port cleared", {rx_valid_o, rx_word_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_oe_o == 1'b0 && slot_n_o == 1'b1, "R9 released after reset", {tx_oe_o, slot_n_o}, 2'b01);

    // R6 startup blanking: BF frames of FL rising edges
    for (int f = 0; f < BF; f++) frame(8'($urandom), 1'b0, 8'h00, 1'b0, 1'b0, "R6 blanked after reset");

    // R4 idle word, then directed corner words
    frame(8'hA5, 1'b1, 8'h80, 1'b1, 1'b0, "");
    frame(8'h5A, 1'b1, 8'h01, 1'b1, 1'b0, "");
    frame(8'h80, 1'b1, 8'h00, 1'b1, 1'b1, "");
    frame(8'h01, 1'b1, 8'hFF, 1'b1, 1'b0, "");
    frame(8'h00, 1'b1, 8'h3C, 1'b1, 1'b1, "");
    frame(8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, "");

    // random frames, some with a second sync inside the slot (R5)
    for (int f = 0; f < 16; f++)
      frame(8'($urandom), 1'($urandom), 8'($urandom), 1'b1, ($urandom % 4) == 0, "");

    // R7 clock loss mid-slot, then R8 blanking again
    loss_test(8'hC3);
    for (int f = 0; f < BF; f++) frame(8'($urandom), 1'b1, 8'($urandom), 1'b0, 1'b0, "R8 blanked after clock returns");
    frame(8'h69, 1'b1, 8'h96, 1'b1, 1'b0, "");
    frame(8'h96, 1'b0, 8'h00, 1'b1, 1'b0, "");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule